// File: doc/BRIEF.md
# Sequencer Run Control and Program Counter

This block is the run-control half of a small command sequencer that fetches 32-bit command words from a fixed memory window. A control bit picks where the run enable comes from: an external power-controller input, or a software start/stop bit. The block keeps a word-aligned program counter and presents it on a fetch request/acknowledge interface. It tracks whether the sequencer is fetching, executing, parked after a sleep command, or stopped. The command decoder sits outside the block and reports back when each command ends, when a sleep command ran, and when a bus or opcode error occurred.

Software reaches the block through a small register port with three word registers: control, status and program counter. While the sequencer is halted, software may overwrite the program counter, and the next start fetches from the written address. A self-clearing reset bit pulls the sequencer back to the base offset supplied by the memory controller. Sticky status flags record sleep completion, bus errors and opcode errors. They are cleared only when execution starts again.

Top module: `seq_run_ctrl`

## Requirements
- R1: The effective enable is `pwr_en_i` while control bit 1 (software mode) is 0. While that bit is 1, it is control bit 0 (software enable), and `pwr_en_i` has no effect. Control is register address 0.
- R2: Dropping the effective enable during a command does not halt the sequencer. It halts after `cmd_end_i` and only then sets the stopped flag, which is status bit 5. Status is register address 1.
- R3: The fetch address is `WIN_BASE | (pc << 2)`. Each fetch acknowledge advances the word counter by one (4 bytes), and the counter wraps inside the `PC_HI:2` field.
- R4: `fetch_req_o` and `fetch_addr_o` stay unchanged from the cycle a request is raised until the cycle `fetch_ack_i` is seen.
- R5: A write to register address 2 loads only data bits `PC_HI:2` into the counter, and only while the stopped flag is set. An accepted write sets status bit 6 (loaded). A write while running is discarded. Reading address 2 returns the full fetch address.
- R6: Leaving the stopped state starts fetching. The start uses the written counter if the loaded flag is set, otherwise `base_off_i`. It clears the loaded, done, bus-error and opcode-error flags.
- R7: `cmd_end_i` together with `cmd_sleep_i` during a command drives `done_pulse_o` high in that same cycle. It sets the sticky done flag (status bit 2), and no further fetch is issued until a start.
- R8: `bus_err_i` sets status bit 3 only while control bit 2 (error detect enable) is 1. `op_err_i` sets status bit 4. Both flags are sticky and execution continues.
- R9: After `rst_ni`, the status register reads 0x20, the control register reads 0, and no fetch is requested.
- R10: Writing 1 to control bit 3 reads back as 1 for one cycle. On the next clock the bit clears itself, and the sequencer aborts any command, reloads `base_off_i`, and clears all flags. It resumes fetching if the enable is high and stops otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| base_off_i | input | PC_HI-1 | Base word offset within the window |
| pwr_en_i | input | 1 | Hardware run enable from power controller |
| fetch_req_o | output | 1 | Command word fetch request |
| fetch_addr_o | output | 32 | Fetch byte address |
| fetch_ack_i | input | 1 | Fetch acknowledge |
| cmd_end_i | input | 1 | Current command finished |
| cmd_sleep_i | input | 1 | Finished command was a sleep |
| bus_err_i | input | 1 | Bus error seen by the decoder |
| op_err_i | input | 1 | Unknown opcode seen by the decoder |
| done_pulse_o | output | 1 | One-cycle done event to power controller |

## Verification
The bench builds the block with `PC_HI = 6`, which gives a 5-bit word counter and a 32-word window. With that size, a run of 40 acknowledged fetches crosses the counter wrap, and every legal counter value can be written and read back while stopped. Each counter write also sets the data bits outside field 6:2, to show that they are dropped. The sequence covers stops in the middle of a command, sleep parking, restarts with and without a loaded counter, and a soft reset during a command with a changed base offset.

// File: rtl/seq_rc_pkg.sv
package seq_rc_pkg;
  typedef enum logic [1:0] {ST_STOP, ST_FETCH, ST_EXEC, ST_SLEEP} run_st_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_PC   = 2'd2;

  localparam int CB_SW_EN  = 0;
  localparam int CB_SW_SEL = 1;
  localparam int CB_BE_DET = 2;
  localparam int CB_SRST   = 3;

  localparam int SB_DONE   = 2;
  localparam int SB_BERR   = 3;
  localparam int SB_OPERR  = 4;
  localparam int SB_STOP   = 5;
  localparam int SB_LOADED = 6;
endpackage

// File: rtl/seq_rc_ctrl.sv
module seq_rc_ctrl
  import seq_rc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ctrl_i,
  input  logic [3:0] wdata_i,
  input  logic       pwr_en_i,
  output logic       sw_en_o,
  output logic       sw_sel_o,
  output logic       be_det_o,
  output logic       soft_rst_o,
  output logic       en_eff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_en_o    <= 1'b0;
      sw_sel_o   <= 1'b0;
      be_det_o   <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      soft_rst_o <= wr_ctrl_i && wdata_i[CB_SRST];
      if (wr_ctrl_i) begin
        sw_en_o  <= wdata_i[CB_SW_EN];
        sw_sel_o <= wdata_i[CB_SW_SEL];
        be_det_o <= wdata_i[CB_BE_DET];
      end
    end
  end

  assign en_eff_o = sw_sel_o ? sw_en_o : pwr_en_i;

  AST_SRST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_o && !(wr_ctrl_i && wdata_i[CB_SRST])) |=> !soft_rst_o); // R10
  AST_SW_SEL_IGNORES_HW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_sel_o |-> (en_eff_o == sw_en_o)); // R1
endmodule

// File: rtl/seq_rc_fsm.sv
module seq_rc_fsm
  import seq_rc_pkg::*;
#(
  parameter int PC_W = 17
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_eff_i,
  input  logic            soft_rst_i,
  input  logic            fetch_ack_i,
  input  logic            cmd_end_i,
  input  logic            cmd_sleep_i,
  input  logic            pc_wr_i,
  input  logic [PC_W-1:0] pc_wdata_i,
  input  logic [PC_W-1:0] base_off_i,
  output run_st_e         state_o,
  output logic [PC_W-1:0] pc_o,
  output logic            loaded_o,
  output logic            start_o,
  output logic            done_pulse_o,
  output logic            fetch_req_o
);
  run_st_e         st_q;
  logic [PC_W-1:0] pc_q;
  logic            ld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_STOP;
      pc_q <= '0;
      ld_q <= 1'b0;
    end else if (soft_rst_i) begin
      st_q <= en_eff_i ? ST_FETCH : ST_STOP;
      pc_q <= base_off_i;
      ld_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_STOP: begin
          if (en_eff_i) begin
            st_q <= ST_FETCH;
            ld_q <= 1'b0;
            if (!ld_q) pc_q <= base_off_i;
          end else if (pc_wr_i) begin
            pc_q <= pc_wdata_i;
            ld_q <= 1'b1;
          end
        end
        ST_FETCH: begin
          if (fetch_ack_i) begin
            pc_q <= pc_q + PC_W'(1);
            st_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (cmd_end_i) begin
            if (cmd_sleep_i)   st_q <= ST_SLEEP;
            else if (en_eff_i) st_q <= ST_FETCH;
            else               st_q <= ST_STOP;
          end
        end
        ST_SLEEP: begin
          if (!en_eff_i) st_q <= ST_STOP;
        end
        default: st_q <= ST_STOP;
      endcase
    end
  end

  assign state_o      = st_q;
  assign pc_o         = pc_q;
  assign loaded_o     = ld_q;
  assign fetch_req_o  = (st_q == ST_FETCH);
  assign start_o      = (st_q == ST_STOP) && en_eff_i && !soft_rst_i;
  assign done_pulse_o = (st_q == ST_EXEC) && cmd_end_i && cmd_sleep_i && !soft_rst_i;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !fetch_ack_i && !soft_rst_i) |=> (fetch_req_o && $stable(pc_q))); // R4
  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_ack_i && !soft_rst_i) |=> (pc_q == $past(pc_q) + PC_W'(1))); // R3
  AST_NO_EARLY_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_EXEC) && !cmd_end_i && !soft_rst_i) |=> (st_q == ST_EXEC)); // R2
  AST_PC_FROZEN_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_EXEC || st_q == ST_SLEEP) && !soft_rst_i) |=> $stable(pc_q)); // R5
  AST_SLEEP_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_pulse_o) |=> !fetch_req_o); // R7
  AST_SRST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (pc_q == $past(base_off_i) && !ld_q)); // R10
endmodule

// File: rtl/seq_rc_status.sv
module seq_rc_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic done_set_i,
  input  logic berr_set_i,
  input  logic operr_set_i,
  output logic done_o,
  output logic berr_o,
  output logic operr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      berr_o  <= 1'b0;
      operr_o <= 1'b0;
    end else if (clr_i) begin
      done_o  <= 1'b0;
      berr_o  <= 1'b0;
      operr_o <= 1'b0;
    end else begin
      done_o  <= done_o  | done_set_i;
      berr_o  <= berr_o  | berr_set_i;
      operr_o <= operr_o | operr_set_i;
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((berr_o || operr_o) && !clr_i) |=> (berr_o || operr_o)); // R8
  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_set_i && !clr_i) |=> done_o); // R7
endmodule

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl
  import seq_rc_pkg::*;
#(
  parameter int          PC_HI    = 18,
  parameter logic [31:0] WIN_BASE = 32'h2000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [PC_HI-2:0]  base_off_i,
  input  logic              pwr_en_i,
  output logic              fetch_req_o,
  output logic [31:0]       fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic              cmd_end_i,
  input  logic              cmd_sleep_i,
  input  logic              bus_err_i,
  input  logic              op_err_i,
  output logic              done_pulse_o
);
  localparam int PC_W = PC_HI - 1;

  logic            sw_en, sw_sel, be_det, soft_rst, en_eff;
  logic            wr_ctrl, wr_pc;
  run_st_e         state;
  logic [PC_W-1:0] pc;
  logic            loaded, start;
  logic            f_done, f_berr, f_operr, stopped;

  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_pc   = reg_we_i && (reg_addr_i == REG_PC);

  seq_rc_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_ctrl),
    .wdata_i    (reg_wdata_i[3:0]),
    .pwr_en_i   (pwr_en_i),
    .sw_en_o    (sw_en),
    .sw_sel_o   (sw_sel),
    .be_det_o   (be_det),
    .soft_rst_o (soft_rst),
    .en_eff_o   (en_eff)
  );

  seq_rc_fsm #(.PC_W(PC_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_eff_i     (en_eff),
    .soft_rst_i   (soft_rst),
    .fetch_ack_i  (fetch_ack_i),
    .cmd_end_i    (cmd_end_i),
    .cmd_sleep_i  (cmd_sleep_i),
    .pc_wr_i      (wr_pc),
    .pc_wdata_i   (reg_wdata_i[PC_HI:2]),
    .base_off_i   (base_off_i),
    .state_o      (state),
    .pc_o         (pc),
    .loaded_o     (loaded),
    .start_o      (start),
    .done_pulse_o (done_pulse_o),
    .fetch_req_o  (fetch_req_o)
  );

  seq_rc_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start || soft_rst),
    .done_set_i  (done_pulse_o),
    .berr_set_i  (bus_err_i && be_det),
    .operr_set_i (op_err_i),
    .done_o      (f_done),
    .berr_o      (f_berr),
    .operr_o     (f_operr)
  );

  assign stopped      = (state == ST_STOP);
  assign fetch_addr_o = WIN_BASE | (32'(pc) << 2);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[CB_SW_EN]  = sw_en;
        reg_rdata_o[CB_SW_SEL] = sw_sel;
        reg_rdata_o[CB_BE_DET] = be_det;
        reg_rdata_o[CB_SRST]   = soft_rst;
      end
      REG_STAT: begin
        reg_rdata_o[SB_DONE]   = f_done;
        reg_rdata_o[SB_BERR]   = f_berr;
        reg_rdata_o[SB_OPERR]  = f_operr;
        reg_rdata_o[SB_STOP]   = stopped;
        reg_rdata_o[SB_LOADED] = loaded;
      end
      REG_PC:  reg_rdata_o = fetch_addr_o;
      default: reg_rdata_o = '0;
    endcase
  end

  AST_LOAD_ONLY_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loaded && !stopped) |=> !loaded); // R5
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !(loaded || f_done || f_berr || f_operr)); // R6
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fetch_addr_o & ~(32'((64'd1 << (PC_HI + 1)) - 1))) == (WIN_BASE & ~(32'((64'd1 << (PC_HI + 1)) - 1))))); // R3
endmodule

// File: tb/seq_run_ctrl_bench.sv
module seq_run_ctrl_bench;
  localparam int          PC_HI = 6;
  localparam int          PC_W  = PC_HI - 1;
  localparam logic [31:0] WIN   = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [PC_W-1:0] base = 5'd3;
  logic pwr_en = 1'b0, ack = 1'b0, cend = 1'b0, csleep = 1'b0, berr = 1'b0, operr = 1'b0;
  logic freq, dpulse;
  logic [31:0] faddr;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  seq_run_ctrl #(.PC_HI(PC_HI), .WIN_BASE(WIN)) u_seq_run_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .base_off_i(base),
    .pwr_en_i(pwr_en), .fetch_req_o(freq), .fetch_addr_o(faddr),
    .fetch_ack_i(ack), .cmd_end_i(cend), .cmd_sleep_i(csleep),
    .bus_err_i(berr), .op_err_i(operr), .done_pulse_o(dpulse)
  );

  function automatic logic [31:0] wa(input int w);
    return WIN | (32'(w % 32) << 2);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_reg(input logic [1:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v, exp, tag);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_end();
    cend = 1'b1; step(); cend = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk_reg(2'd1, 32'h20, "R9 status reset");
    chk_reg(2'd0, 32'h0, "R9 ctrl reset");
    chk({31'd0, freq}, 32'd0, "R9 no fetch");

    // hardware enable path
    pwr_en = 1'b1; step();
    chk({31'd0, freq}, 32'd1, "R1 hw enable starts");
    chk(faddr, wa(3), "R6 start at base");
    for (int k = 0; k < 3; k++) begin
      step();
      chk({31'd0, freq}, 32'd1, "R4 request held");
      chk(faddr, wa(3), "R4 address held");
    end

    for (int i = 0; i < 40; i++) begin
      pulse_ack();
      chk({31'd0, freq}, 32'd0, "R3 exec after ack");
      chk_reg(2'd2, wa(3 + i + 1), "R3 pc advance");
      pulse_end();
      chk({31'd0, freq}, 32'd1, "R3 next fetch");
      chk(faddr, wa(3 + i + 1), "R3 wrap address");
    end

    // pc write while running: discarded
    wr(2'd2, WIN | (32'd5 << 2));
    chk_reg(2'd2, wa(11), "R5 write discarded running");
    chk_reg(2'd1, 32'h0, "R5 no loaded flag running");

    // software mode, stop mid-command
    wr(2'd0, 32'h3);
    pulse_ack();
    wr(2'd0, 32'h2);
    chk_reg(2'd1, 32'h0, "R2 not stopped during command");
    step(); step();
    chk_reg(2'd1, 32'h0, "R2 still running until end");
    pulse_end();
    chk_reg(2'd1, 32'h20, "R2 stopped after command end");
    chk({31'd0, freq}, 32'd0, "R2 no fetch when stopped");
    step();
    chk_reg(2'd1, 32'h20, "R1 hw enable ignored in sw mode");

    // pc writes while stopped, out-of-field bits set
    for (int v = 0; v < 32; v++) begin
      wr(2'd2, 32'hFFFF_FF83 | (32'(v) << 2));
      chk_reg(2'd2, wa(v), "R5 pc write sweep");
    end
    wr(2'd2, 32'hFFFF_FF83 | (32'd9 << 2));
    chk_reg(2'd1, 32'h60, "R5 loaded flag set");

    wr(2'd0, 32'h3);
    step();
    chk({31'd0, freq}, 32'd1, "R6 restart fetch");
    chk(faddr, wa(9), "R6 start at loaded pc");
    chk_reg(2'd1, 32'h0, "R6 loaded cleared");

    // error flags
    berr = 1'b1; step(); berr = 1'b0;
    chk_reg(2'd1, 32'h0, "R8 bus error masked");
    wr(2'd0, 32'h7);
    berr = 1'b1; step(); berr = 1'b0;
    chk_reg(2'd1, 32'h08, "R8 bus error captured");
    operr = 1'b1; step(); operr = 1'b0;
    chk_reg(2'd1, 32'h18, "R8 opcode error captured");
    pulse_ack();
    pulse_end();
    chk(faddr, wa(10), "R8 execution continues");
    chk_reg(2'd1, 32'h18, "R8 flags sticky");

    // sleep
    pulse_ack();
    chk({31'd0, dpulse}, 32'd0, "R7 no pulse before sleep");
    cend = 1'b1; csleep = 1'b1; #2;
    chk({31'd0, dpulse}, 32'd1, "R7 done pulse same cycle");
    step(); cend = 1'b0; csleep = 1'b0; #2;
    chk({31'd0, dpulse}, 32'd0, "R7 pulse one cycle");
    chk_reg(2'd1, 32'h1C, "R7 done flag set");
    step(); step(); step();
    chk({31'd0, freq}, 32'd0, "R7 parked after sleep");

    // restart via sw enable toggle
    wr(2'd0, 32'h6);
    step();
    chk_reg(2'd1, 32'h3C, "R7 done held while stopped");
    wr(2'd0, 32'h7);
    step();
    chk_reg(2'd1, 32'h0, "R6 restart clears flags");
    chk(faddr, wa(3), "R6 restart from base");

    // soft reset mid-command with new base
    pulse_ack();
    berr = 1'b1; step(); berr = 1'b0;
    chk_reg(2'd1, 32'h08, "R10 flag before reset");
    base = 5'd20;
    wr(2'd0, 32'hF);
    chk_reg(2'd0, 32'hF, "R10 reset bit visible");
    step();
    chk_reg(2'd0, 32'h7, "R10 reset bit self-clears");
    chk_reg(2'd1, 32'h0, "R10 flags cleared");
    chk({31'd0, freq}, 32'd1, "R10 command aborted, fetching");
    chk(faddr, wa(20), "R10 reload base");

    summary();
  end
endmodule